// File: doc/BRIEF.md
# CPU Clock Divider and Source Switchover Controller

This block produces the single-cycle clock enable that paces a CPU core. It picks one of two sources. The fast main source can be divided by 1, 2, 4, 8 or 16. The slow subsystem source is passed through undivided. Everything runs on one fast reference clock. Each source arrives as a one-cycle tick, and the CPU enable is an output pulse on that same clock.

Software sets a 3-bit divide code and a source-select bit through a small write port. A new setting never takes effect on the write itself. It is held back until a safe boundary:

- A divide change on the main source waits for the wrap of a free-running 4-bit tick counter, so every divided rate restarts in phase and no shortened period appears.
- A move to the subsystem source waits for the next subsystem tick.
- A move back to the main source lets the subsystem deliver one last enable first, then waits for the first matching main-source enable.

A status bit in the read data reports the source that is actually driving the enable, not the one that was requested.

Top module: `cpuclk_switch`

## Requirements
- R1: After reset the read data is 0x00: main source, divide code 000, status 0. The cfg_err output is 0 and cpu_ce is 0.
- R2: On the main source, count main ticks n = 0, 1, 2 … from reset. The tick numbered n produces a cpu_ce pulse when (n+1) is a multiple of 2^k. For codes 000 to 100, k equals the code. The pulse is one cycle high and appears in the cycle after the tick is sampled.
- R3: Divide codes 101, 110 and 111 divide by 16. They read back exactly as written.
- R4: A new divide code written while on the main source takes effect only at a main tick whose number n satisfies (n+1) mod 16 = 0. That tick still pulses under the old code, and later ticks follow the new code.
- R5: Read data layout: bits 2:0 hold the requested divide code, bit 4 holds the requested source (1 = subsystem), and bit 5 holds the active source. Bits 3, 6 and 7 read 0. Writes ignore every bit except 2:0 and 4.
- R6: After a request for the subsystem source, the switch happens at the next subsystem tick. That tick gives a cpu_ce pulse, and status bit 5 rises in the same cycle. From then on, cpu_ce follows only subsystem ticks.
- R7: After a request for the main source while on the subsystem source, the next subsystem tick still gives one pulse. After that, no pulse occurs until the first main tick that matches the requested divide code under R2. That tick gives a pulse, and status bit 5 falls in the same cycle.
- R8: A write that requests the subsystem source while the main source is requested, and also changes the divide code, still switches the source. It keeps the old divide code and sets cfg_err, which stays set until reset.
- R9: A write that requests the main source while the subsystem source is requested may also change the divide code. This does not set cfg_err, and the new code is used after the switch back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| main_tick | input | 1 | One-cycle tick from the main source |
| sub_tick | input | 1 | One-cycle tick from the subsystem source |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write value |
| rd_data | output | 8 | Control register and status read value |
| cpu_ce | output | 1 | Single-cycle CPU clock enable |
| cfg_err | output | 1 | Sticky flag for an unsupported combined write |

## Verification
The bench builds the block with its default parameters: a 4-bit phase counter, a 3-bit divide code and an 8-bit data path. These values bring every divide rate and all three reserved codes within reach, and a 16-tick wrap window short enough to cross many times in one run. A cycle-level scoreboard predicts every cpu_ce pulse and the status bit for each cycle. It is exercised with main ticks both every cycle and every other cycle, and with a subsystem tick every seventh cycle. Under these patterns the deferred divide change, both source handovers and the combined-write error case each occur with the phase counter at different positions.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    // Field positions of the control word (software decodes these)
    localparam int FLD_DIV_LSB  = 0;
    localparam int FLD_SRC_BIT  = 4;
    localparam int FLD_STAT_BIT = 5;

    // Which source drives the CPU enable
    typedef enum logic [1:0] {
        ST_MAIN     = 2'd0,   // main source, divided
        ST_SUB      = 2'd1,   // subsystem source
        ST_HANDBACK = 2'd2    // subsystem delivered its last pulse, awaiting main
    } clk_state_e;

endpackage

// File: rtl/cpuclk_phase.sv
module cpuclk_phase #(
    parameter int CNT_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           main_tick,
    output logic [CNT_W:0] strobe,
    output logic           wrap
);
    localparam int NSTB = CNT_W + 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (main_tick) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // strobe[k]: main tick at which a divide-by-2^k output fires
    for (genvar k = 0; k < NSTB; k++) begin : g_stb
        if (k == 0) begin : g_full
            assign strobe[k] = main_tick;
        end else begin : g_div
            assign strobe[k] = main_tick & (&cnt_q[k-1:0]);
        end
    end

    assign wrap = strobe[CNT_W];

    // After a wrap the counter restarts at zero (R4)
    p_wrap_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));

endmodule

// File: rtl/cpuclk_ctrl_reg.sv
module cpuclk_ctrl_reg #(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_div,
    input  logic              wr_src,
    output logic [CODE_W-1:0] req_div,
    output logic              req_src,
    output logic              err
);
    typedef struct packed {
        logic [CODE_W-1:0] div;
        logic              src;
        logic              err;
    } reg_t;

    reg_t r_d, r_q;
    logic mixed_wr;

    // main->sub request combined with a divide change
    assign mixed_wr = wr_en && !r_q.src && wr_src && (wr_div != r_q.div);

    always_comb begin
        r_d = r_q;
        if (mixed_wr) begin
            r_d.src = 1'b1;
            r_d.err = 1'b1;
        end else if (wr_en) begin
            r_d.div = wr_div;
            r_d.src = wr_src;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign req_div = r_q.div;
    assign req_src = r_q.src;
    assign err     = r_q.err;

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    p_mixed_keeps_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !req_src && wr_src && (wr_div != req_div))
            |=> (req_src && err && $stable(req_div)));

    p_legal_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && req_src && !wr_src) |=> (!req_src && (req_div == $past(wr_div))));

endmodule

// File: rtl/cpuclk_fsm.sv
module cpuclk_fsm
    import cpuclk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic [CNT_W:0]    strobe,
    input  logic              wrap,
    input  logic [CODE_W-1:0] req_div,
    input  logic              req_src,
    output logic              cpu_ce,
    output logic              act_src
);
    typedef struct packed {
        clk_state_e        st;
        logic [CODE_W-1:0] div;
        logic              ce;
    } fsm_t;

    fsm_t s_d, s_q;
    logic hit_cur, hit_req;

    // Select the strobe for a code; codes at or above CNT_W use the slowest
    function automatic logic pick(input logic [CODE_W-1:0] code,
                                  input logic [CNT_W:0]    stb);
        logic hit;
        hit = stb[CNT_W];
        for (int k = 0; k < CNT_W; k++) begin
            if (int'(code) == k) hit = stb[k];
        end
        return hit;
    endfunction

    assign hit_cur = pick(s_q.div, strobe);
    assign hit_req = pick(req_div, strobe);

    always_comb begin
        s_d    = s_q;
        s_d.ce = 1'b0;
        unique case (s_q.st)
            ST_MAIN: begin
                if (req_src && sub_tick) begin
                    s_d.st = ST_SUB;
                    s_d.ce = 1'b1;
                end else begin
                    s_d.ce = hit_cur;
                    if (wrap && !req_src) s_d.div = req_div;
                end
            end
            ST_SUB: begin
                s_d.ce = sub_tick;
                if (sub_tick && !req_src) s_d.st = ST_HANDBACK;
            end
            ST_HANDBACK: begin
                if (req_src) begin
                    s_d.st = ST_SUB;
                    s_d.ce = sub_tick;
                end else if (hit_req) begin
                    s_d.st  = ST_MAIN;
                    s_d.div = req_div;
                    s_d.ce  = 1'b1;
                end
            end
            default: s_d.st = ST_MAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.st  <= ST_MAIN;
            s_q.div <= '0;
            s_q.ce  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign cpu_ce  = s_q.ce;
    assign act_src = (s_q.st != ST_MAIN);

    p_ce_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ce |-> $past(main_tick || sub_tick));

    p_div_only_at_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_MAIN) && ($past(s_q.st) == ST_MAIN) && (s_q.div != $past(s_q.div)))
            |-> $past(wrap));

    p_status_rise_ce_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(act_src) |-> cpu_ce);

    p_sub_pulse_from_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_SUB) && cpu_ce) |-> $past(sub_tick));

    p_status_fall_ce_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_src) |-> cpu_ce);

endmodule

// File: rtl/cpuclk_switch.sv
module cpuclk_switch
    import cpuclk_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int CODE_W = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              main_tick,
    input  logic              sub_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              cpu_ce,
    output logic              cfg_err
);
    localparam int NSTB = CNT_W + 1;

    logic [NSTB-1:0]   strobe;
    logic              wrap;
    logic [CODE_W-1:0] req_div;
    logic              req_src;
    logic              act_src;
    logic              wr_unused;

    // Bits outside the divide and source fields are ignored on write (R5)
    assign wr_unused = ^{wr_data[DATA_W-1:FLD_STAT_BIT], wr_data[FLD_SRC_BIT-1:CODE_W]};

    cpuclk_phase #(.CNT_W(CNT_W)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .strobe    (strobe),
        .wrap      (wrap)
    );

    cpuclk_ctrl_reg #(.CODE_W(CODE_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_div  (wr_data[FLD_DIV_LSB +: CODE_W]),
        .wr_src  (wr_data[FLD_SRC_BIT]),
        .req_div (req_div),
        .req_src (req_src),
        .err     (cfg_err)
    );

    cpuclk_fsm #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .strobe    (strobe),
        .wrap      (wrap),
        .req_div   (req_div),
        .req_src   (req_src),
        .cpu_ce    (cpu_ce),
        .act_src   (act_src)
    );

    always_comb begin
        rd_data                            = '0;
        rd_data[FLD_DIV_LSB +: CODE_W]     = req_div;
        rd_data[FLD_SRC_BIT]               = req_src;
        rd_data[FLD_STAT_BIT]              = act_src;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!cpu_ce && !act_src));

endmodule

// File: tb/sim_cpuclk_switch.sv
module sim_cpuclk_switch;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       main_tick = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       cpu_ce;
    logic       cfg_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        logic  ce;
        logic  stat;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    // Reference state, built from the requirements
    int         r_n = 0;        // main ticks modulo 16
    int         r_st = 0;       // 0 main, 1 sub, 2 waiting to return
    logic [2:0] r_div = 3'd0;
    logic [2:0] r_reqdiv = 3'd0;
    logic       r_reqsrc = 1'b0;
    logic       r_err = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cpuclk_switch u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .main_tick (main_tick),
        .sub_tick  (sub_tick),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .cpu_ce    (cpu_ce),
        .cfg_err   (cfg_err)
    );

    function automatic int shf(input logic [2:0] code);
        return (code > 3'd4) ? 4 : int'(code);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: applies one cycle of stimulus and pushes the predicted result
    task automatic step(input logic we, input logic [7:0] wd,
                        input logic mt, input logic st);
        exp_t e;
        logic hit_old, hit_new, wrap_now;
        @(negedge clk);
        wr_en = we; wr_data = wd; main_tick = mt; sub_tick = st;
        hit_old  = mt && (((r_n + 1) % (1 << shf(r_div))) == 0);
        hit_new  = mt && (((r_n + 1) % (1 << shf(r_reqdiv))) == 0);
        wrap_now = mt && (r_n == 15);
        e.ce = 1'b0;
        e.tag = "R2";
        case (r_st)
            0: begin
                if (r_reqsrc && st) begin
                    r_st = 1; e.ce = 1'b1; e.tag = "R6";
                end else begin
                    e.ce = hit_old;
                    e.tag = (r_div > 3'd4) ? "R3" : "R2";
                    if (wrap_now && !r_reqsrc) begin
                        if (r_reqdiv != r_div) e.tag = "R4";
                        r_div = r_reqdiv;
                    end
                end
            end
            1: begin
                e.ce = st; e.tag = "R6";
                if (st && !r_reqsrc) r_st = 2;
            end
            default: begin
                if (r_reqsrc) begin
                    r_st = 1; e.ce = st; e.tag = "R6";
                end else begin
                    e.tag = "R7";
                    if (hit_new) begin
                        r_st = 0; r_div = r_reqdiv; e.ce = 1'b1;
                    end
                end
            end
        endcase
        e.stat = (r_st != 0);
        if (mt) r_n = (r_n + 1) % 16;
        if (we) begin
            if (!r_reqsrc && wd[4] && (wd[2:0] != r_reqdiv)) begin
                r_err = 1'b1; r_reqsrc = 1'b1;
            end else begin
                r_reqdiv = wd[2:0]; r_reqsrc = wd[4];
            end
        end
        exp_q.push_back(e);
    endtask

    // Checks the register fields after a write has been registered
    task automatic chk_rd(input string tag);
        check({tag, " rd fields"}, int'(rd_data & 8'hDF), int'({3'b000, r_reqsrc, 1'b0, r_reqdiv}));
        check({tag, " cfg_err"}, int'(cfg_err), int'(r_err));
    endtask

    task automatic run(input int cycles, input int mt_every, input int st_every);
        for (int i = 0; i < cycles; i++) begin
            step(1'b0, 8'h00, (i % mt_every) == 0, (i % st_every) == (st_every - 1));
        end
    endtask

    // Monitor: pops one prediction per clock and compares
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_cmp++;
            if (cpu_ce !== e.ce) begin
                n_bad++;
                $display("FAIL %s cpu_ce actual=%0b expected=%0b at %0t", e.tag, cpu_ce, e.ce, $time);
            end
            n_cmp++;
            if (rd_data[5] !== e.stat) begin
                n_bad++;
                $display("FAIL %s status actual=%0b expected=%0b at %0t", e.tag, rd_data[5], e.stat, $time);
            end
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 rd_data", int'(rd_data), 0);
        check("R1 cfg_err", int'(cfg_err), 0);
        check("R1 cpu_ce", int'(cpu_ce), 0);

        // R2: divide by 1, main tick every cycle
        run(40, 1, 1000);
        // R4: change to /4 mid-phase, main tick every other cycle
        step(1'b1, 8'h02, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk_rd("R5 div2");
        run(80, 2, 1000);
        // R3: reserved code acts as /16 and reads back
        step(1'b1, 8'h06, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_rd("R3 code6");
        run(70, 1, 1000);
        // R5: extra bits ignored, code 3
        step(1'b1, 8'hE3, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_rd("R5 ignore");
        check("R5 upper bits", int'(rd_data[7:6]), 0);
        run(40, 1, 1000);
        // R6: to subsystem with same code
        step(1'b1, 8'h13, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_rd("R6 req");
        run(50, 1, 7);
        // R9: back to main with new code /2, no error
        step(1'b1, 8'h01, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_rd("R9 return");
        run(50, 1, 7);
        check("R9 no error", int'(cfg_err), 0);
        // R8: divide change together with main-to-sub
        step(1'b1, 8'h14, 1'b1, 1'b0);
        step(1'b0, 8'h00, 1'b1, 1'b0);
        chk_rd("R8 mixed");
        check("R8 kept div", int'(rd_data[2:0]), 1);
        run(50, 1, 7);
        // R7: back to main with /8, sub ticks sparse
        step(1'b1, 8'h03, 1'b0, 1'b0);
        step(1'b0, 8'h00, 1'b0, 1'b0);
        chk_rd("R7 return");
        run(60, 1, 11);
        check("R8 sticky", int'(cfg_err), 1);

        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule